// File: doc/BRIEF.md
# Subtract and Compare Flag Unit

This block is the subtract side of an accumulator-style processor's arithmetic path. On each cycle in which the valid strobe is high, it takes one of four operations: subtract-with-borrow into the accumulator, or a compare of the accumulator, X or Y against a memory operand. On the next rising clock edge it registers the 8-bit result together with the negative, zero, carry and overflow flags. Each flag and the result have a one-cycle update enable, so the surrounding core knows which status bits to take.

A subtract uses the incoming carry as an inverted borrow. When the decimal-mode input is set, it also applies packed-BCD correction to the value written back. The flags always come from the plain binary difference, whichever value is written. A compare always runs in binary with no borrow. It writes no register and keeps the overflow flag. Because the carry out of a compare feeds the next subtract unchanged, a compare on the low bytes followed by a subtract on the high bytes gives a 16-bit unsigned greater-or-equal test.

The caller places the register being compared (A, X or Y) on the single minuend input. The operation code then chooses the behaviour.

Top module: `sbc_cmp_unit`

## Requirements
- R1: A synchronous active-high reset clears the result, all four flags and all five update enables.
- R2: With op_i = 2'b00 (subtract), the result is reg_i − mem_i − (1 − carry_i) modulo 256 when dec_i is 0. The result write enable and all four flag enables pulse for the one cycle after the valid edge.
- R3: After a subtract or compare, the carry flag is 1 exactly when the full difference, borrow included, is not below zero (unsigned minuend ≥ subtrahend plus borrow).
- R4: The negative flag is bit 7 of the low byte of the binary difference. The zero flag is set when that byte is all zeros.
- R5: After a subtract, overflow is set when the minuend and subtrahend differ in bit 7 and the minuend and binary difference also differ in bit 7.
- R6: A compare (op_i = 2'b01, 2'b10 or 2'b11) ignores carry_i and uses no borrow. It leaves the result and the overflow flag unchanged, keeps the result and overflow enables low, and pulses the carry, negative and zero enables.
- R7: A compare runs in binary whatever the value of dec_i.
- R8: A subtract with dec_i = 1 on valid packed-BCD operands writes the packed-BCD value of (decimal minuend − decimal subtrahend − borrow) modulo 100.
- R9: In a decimal subtract, the carry, negative, zero and overflow flags are those of the binary difference of the same operands and borrow.
- R10: While valid_i is low, no flag or result changes and every update enable is low.
- R11: The two index-register compares (2'b10, 2'b11) behave exactly like the accumulator compare (2'b01) on the given minuend.
- R12: A compare of the low bytes followed by a subtract of the high bytes, with the carry output fed back as carry_i, leaves carry = 1 exactly when the 16-bit minuend is ≥ the 16-bit subtrahend.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 2 | 00 subtract, 01 compare A, 10 compare X, 11 compare Y |
| reg_i | input | 8 | Minuend: accumulator, X or Y |
| mem_i | input | 8 | Subtrahend from memory |
| carry_i | input | 1 | Current carry flag (inverted borrow) |
| dec_i | input | 1 | Decimal-mode flag |
| res_o | output | 8 | Registered result |
| res_we_o | output | 1 | Result write enable pulse |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| c_o | output | 1 | Carry flag |
| v_o | output | 1 | Overflow flag |
| n_upd_o | output | 1 | Negative update enable |
| z_upd_o | output | 1 | Zero update enable |
| c_upd_o | output | 1 | Carry update enable |
| v_upd_o | output | 1 | Overflow update enable |

## Verification
Two functions share one cycle in a decimal subtract: the BCD correction that forms the written value, and the flag logic working on the uncorrected binary difference. The bench provokes this with operands such as 0x80 minus 0x01. The written value is then 0x79, while the flags show overflow set and negative clear from the binary 0x7F. It judges the value against a decimal-arithmetic model and the flags against a separate binary model. The same pairing shows up when a compare follows a subtract that set overflow. In that case the compare's new carry and zero must land in the same cycle in which overflow and the result are held.

// File: rtl/sbc_cmp_pkg.sv
package sbc_cmp_pkg;

    typedef enum logic [1:0] {
        OP_SUB  = 2'b00,
        OP_CMPA = 2'b01,
        OP_CMPX = 2'b10,
        OP_CMPY = 2'b11
    } sc_op_e;

    typedef struct packed {
        logic neg;
        logic zero;
        logic carry;
        logic ovf;
    } sc_flags_t;

endpackage

// File: rtl/sc_bin_core.sv
module sc_bin_core #(
    parameter int DW = 8
) (
    input  logic [DW-1:0]            min_i,
    input  logic [DW-1:0]            sub_i,
    input  logic                     borrow_i,
    output logic [DW-1:0]            diff_o,
    output sbc_cmp_pkg::sc_flags_t   flags_o
);
    localparam int MSB = DW - 1;

    logic [DW:0] wide;

    always_comb begin
        wide          = {1'b0, min_i} - {1'b0, sub_i} - {{DW{1'b0}}, borrow_i};
        diff_o        = wide[MSB:0];
        flags_o.carry = ~wide[DW];
        flags_o.neg   = wide[MSB];
        flags_o.zero  = (wide[MSB:0] == '0);
        flags_o.ovf   = (min_i[MSB] ^ wide[MSB]) & (min_i[MSB] ^ sub_i[MSB]);
    end

endmodule

// File: rtl/sc_bcd_core.sv
module sc_bcd_core #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] min_i,
    input  logic [DW-1:0] sub_i,
    input  logic          borrow_i,
    output logic [DW-1:0] diff_o
);
    localparam int ND = DW / 4;

    logic [ND:0] brw;
    assign brw[0] = borrow_i;

    for (genvar d = 0; d < ND; d++) begin : g_digit
        logic [4:0] raw;
        logic [4:0] adj;
        always_comb begin
            raw = {1'b0, min_i[4*d +: 4]} - {1'b0, sub_i[4*d +: 4]} - {4'b0, brw[d]};
            adj = raw - 5'd6;
        end
        assign diff_o[4*d +: 4] = raw[4] ? adj[3:0] : raw[3:0];
        assign brw[d+1]         = raw[4];
    end

endmodule

// File: rtl/sbc_cmp_unit.sv
module sbc_cmp_unit #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          valid_i,
    input  logic [1:0]    op_i,
    input  logic [DW-1:0] reg_i,
    input  logic [DW-1:0] mem_i,
    input  logic          carry_i,
    input  logic          dec_i,
    output logic [DW-1:0] res_o,
    output logic          res_we_o,
    output logic          n_o,
    output logic          z_o,
    output logic          c_o,
    output logic          v_o,
    output logic          n_upd_o,
    output logic          z_upd_o,
    output logic          c_upd_o,
    output logic          v_upd_o
);
    import sbc_cmp_pkg::*;

    sc_op_e      op;
    logic        is_sub;
    logic        borrow;
    logic [DW-1:0] bin_diff;
    logic [DW-1:0] bcd_diff;
    logic [DW-1:0] wb_val;
    sc_flags_t   fl;

    assign op     = sc_op_e'(op_i);
    assign is_sub = (op == OP_SUB);
    // compares never borrow; subtract borrows when carry is clear
    assign borrow = is_sub & ~carry_i;

    sc_bin_core #(.DW(DW)) u_bin (
        .min_i   (reg_i),
        .sub_i   (mem_i),
        .borrow_i(borrow),
        .diff_o  (bin_diff),
        .flags_o (fl)
    );

    sc_bcd_core #(.DW(DW)) u_bcd (
        .min_i   (reg_i),
        .sub_i   (mem_i),
        .borrow_i(borrow),
        .diff_o  (bcd_diff)
    );

    assign wb_val = dec_i ? bcd_diff : bin_diff;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_o    <= '0;
            res_we_o <= 1'b0;
            n_o      <= 1'b0;
            z_o      <= 1'b0;
            c_o      <= 1'b0;
            v_o      <= 1'b0;
            n_upd_o  <= 1'b0;
            z_upd_o  <= 1'b0;
            c_upd_o  <= 1'b0;
            v_upd_o  <= 1'b0;
        end else begin
            res_we_o <= valid_i & is_sub;
            v_upd_o  <= valid_i & is_sub;
            n_upd_o  <= valid_i;
            z_upd_o  <= valid_i;
            c_upd_o  <= valid_i;
            if (valid_i) begin
                n_o <= fl.neg;
                z_o <= fl.zero;
                c_o <= fl.carry;
                if (is_sub) begin
                    v_o   <= fl.ovf;
                    res_o <= wb_val;
                end
            end
        end
    end

endmodule

// File: rtl/sbc_cmp_chk.sv
module sbc_cmp_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          valid_i,
    input logic [1:0]    op_i,
    input logic [DW-1:0] reg_i,
    input logic [DW-1:0] mem_i,
    input logic [DW-1:0] res_o,
    input logic          res_we_o,
    input logic          c_o,
    input logic          z_o,
    input logic          n_o,
    input logic          v_o,
    input logic          c_upd_o,
    input logic          v_upd_o
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!c_o && !z_o && !n_o && !v_o && !res_we_o && res_o == '0));

    // R2
    sub_enables_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == 2'b00) |=> (res_we_o && v_upd_o && c_upd_o));

    // R6
    cmp_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i != 2'b00) |=> (!res_we_o && !v_upd_o && c_upd_o));

    // R6
    cmp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i != 2'b00) |=> ($stable(res_o) && $stable(v_o)));

    // R7
    cmp_equal_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i != 2'b00 && reg_i == mem_i) |=> (z_o && c_o && !n_o));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> (!res_we_o && !c_upd_o && $stable(c_o) && $stable(z_o)
                      && $stable(n_o) && $stable(v_o) && $stable(res_o)));

endmodule

bind sbc_cmp_unit sbc_cmp_chk #(.DW(DW)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .valid_i (valid_i),
    .op_i    (op_i),
    .reg_i   (reg_i),
    .mem_i   (mem_i),
    .res_o   (res_o),
    .res_we_o(res_we_o),
    .c_o     (c_o),
    .z_o     (z_o),
    .n_o     (n_o),
    .v_o     (v_o),
    .c_upd_o (c_upd_o),
    .v_upd_o (v_upd_o)
);

// File: tb/sbc_cmp_unit_tb_top.sv
module sbc_cmp_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       valid_i;
    logic [1:0] op_i;
    logic [7:0] reg_i, mem_i;
    logic       carry_i, dec_i;
    logic [7:0] res_o;
    logic       res_we_o, n_o, z_o, c_o, v_o;
    logic       n_upd_o, z_upd_o, c_upd_o, v_upd_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sbc_cmp_unit dut_i (
        .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i),
        .reg_i(reg_i), .mem_i(mem_i), .carry_i(carry_i), .dec_i(dec_i),
        .res_o(res_o), .res_we_o(res_we_o),
        .n_o(n_o), .z_o(z_o), .c_o(c_o), .v_o(v_o),
        .n_upd_o(n_upd_o), .z_upd_o(z_upd_o), .c_upd_o(c_upd_o), .v_upd_o(v_upd_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // drive one op for one edge, then sample after it
    task automatic run_op(input logic [1:0] op, input logic [7:0] r, input logic [7:0] m,
                          input logic c, input logic d);
        @(negedge clk);
        valid_i = 1'b1; op_i = op; reg_i = r; mem_i = m; carry_i = c; dec_i = d;
        @(negedge clk);
        valid_i = 1'b0;
    endtask

    // binary reference flags: {n,z,c,v}
    function automatic logic [3:0] bin_flags(input int a, input int m, input int b);
        int d;
        int lo;
        d  = a - m - b;
        lo = d & 255;
        return {lo >= 128, lo == 0, d >= 0, (((a ^ lo) & (a ^ m) & 128) != 0)};
    endfunction

    function automatic int bcd_ref(input int a, input int m, input int b);
        int r;
        r = ((a >> 4) * 10 + (a & 15)) - ((m >> 4) * 10 + (m & 15)) - b;
        if (r < 0) r += 100;
        return ((r / 10) << 4) | (r % 10);
    endfunction

    task automatic t_reset();
        rst = 1'b1; valid_i = 1'b0; op_i = 2'b00; reg_i = 8'hA5; mem_i = 8'h11;
        carry_i = 1'b1; dec_i = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 res", res_o, 0);
        check("R1 flags", {n_o, z_o, c_o, v_o}, 0);
        check("R1 enables", {res_we_o, n_upd_o, z_upd_o, c_upd_o, v_upd_o}, 0);
        rst = 1'b0;
    endtask

    task automatic t_sub_binary();
        logic [7:0] av [6] = '{8'h50, 8'h50, 8'h30, 8'h00, 8'h80, 8'h7F};
        logic [7:0] mv [6] = '{8'h30, 8'h30, 8'h50, 8'h00, 8'h01, 8'hFF};
        logic       cv [6] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};
        for (int i = 0; i < 6; i++) begin
            logic [3:0] f;
            int b;
            b = cv[i] ? 0 : 1;
            f = bin_flags(av[i], mv[i], b);
            run_op(2'b00, av[i], mv[i], cv[i], 1'b0);
            check("R2 sub result", res_o, (av[i] - mv[i] - b) & 255);
            check("R2 enables", {res_we_o, n_upd_o, z_upd_o, c_upd_o, v_upd_o}, 5'b11111);
            check("R3 carry", c_o, f[1]);
            check("R4 neg/zero", {n_o, z_o}, f[3:2]);
            check("R5 overflow", v_o, f[0]);
        end
    endtask

    task automatic t_compare();
        // set V and a known result first
        run_op(2'b00, 8'h80, 8'h01, 1'b1, 1'b0);
        check("R5 setup V", v_o, 1);
        // equal, carry_i clear, decimal set: no borrow, binary
        run_op(2'b01, 8'h40, 8'h40, 1'b0, 1'b1);
        check("R6 cmp carry ignores carry_i", {n_o, z_o, c_o}, 3'b011);
        check("R6 V held", v_o, 1);
        check("R6 result held", res_o, 8'h7F);
        check("R6 enables", {res_we_o, n_upd_o, z_upd_o, c_upd_o, v_upd_o}, 5'b01110);
        // decimal ignored: 0x10-0x01 binary 0x0F (BCD would give 0x09)
        run_op(2'b01, 8'h10, 8'h01, 1'b0, 1'b1);
        check("R7 binary cmp", {n_o, z_o, c_o}, 3'b001);
        run_op(2'b10, 8'h10, 8'h20, 1'b1, 1'b0);
        check("R11 cpx less", {n_o, z_o, c_o}, 3'b100);
        run_op(2'b11, 8'h20, 8'h10, 1'b0, 1'b0);
        check("R11 cpy greater", {n_o, z_o, c_o}, 3'b001);
        run_op(2'b11, 8'hFF, 8'hFF, 1'b0, 1'b1);
        check("R11 cpy equal", {n_o, z_o, c_o, v_o}, 4'b0111);
        check("R6 result held after cpy", res_o, 8'h7F);
    endtask

    task automatic t_decimal();
        logic [7:0] av [4] = '{8'h00, 8'h80, 8'h42, 8'h99};
        logic [7:0] mv [4] = '{8'h01, 8'h01, 8'h15, 8'h99};
        logic       cv [4] = '{1'b1, 1'b1, 1'b0, 1'b1};
        for (int i = 0; i < 4; i++) begin
            logic [3:0] f;
            int b;
            b = cv[i] ? 0 : 1;
            f = bin_flags(av[i], mv[i], b);
            run_op(2'b00, av[i], mv[i], cv[i], 1'b1);
            check("R8 bcd result", res_o, bcd_ref(av[i], mv[i], b));
            check("R9 binary flags", {n_o, z_o, c_o, v_o}, f);
        end
    endtask

    task automatic t_idle();
        logic [12:0] snap;
        run_op(2'b00, 8'h80, 8'h01, 1'b1, 1'b0);
        snap = {res_o, n_o, z_o, c_o, v_o, 1'b0};
        reg_i = 8'h00; mem_i = 8'hFF; op_i = 2'b00; carry_i = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 state held", {res_o, n_o, z_o, c_o, v_o, 1'b0}, snap);
        check("R10 enables low", {res_we_o, n_upd_o, z_upd_o, c_upd_o, v_upd_o}, 0);
    endtask

    task automatic t_chain16();
        logic [15:0] pa [5] = '{16'h1234, 16'h1300, 16'h1234, 16'h0000, 16'hFFFF};
        logic [15:0] pb [5] = '{16'h1235, 16'h12FF, 16'h1234, 16'h0001, 16'hFFFE};
        for (int i = 0; i < 5; i++) begin
            logic c;
            run_op(2'b01, pa[i][7:0], pb[i][7:0], 1'b0, 1'b0);
            c = c_o;
            run_op(2'b00, pa[i][15:8], pb[i][15:8], c, 1'b0);
            check("R12 16-bit ge", c_o, pa[i] >= pb[i]);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_sub_binary();
        t_compare();
        t_decimal();
        t_idle();
        t_chain16();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule